// File: doc/BRIEF.md
# General-Purpose Timer with Capture and PWM

This block is a 32-bit up-counter that a host programs through a small write port. An optional power-of-two prescaler sets the rate at which the counter advances. When the counter passes its all-ones value it either returns to zero or restarts from a programmed reload value. A one-shot setting makes it halt after that wrap. A compare register reports a match and can drive the output pin. A synchronized capture pin stores the running count on the selected edge.

All state is visible on output ports: the live count, the captured value and the three sticky event flags (overflow, compare, capture). The interrupt line is raised when any flag is set and its enable bit is also set. The output pin either toggles on every overflow and compare event or gives a one-clock pulse on each of them, and its polarity can be inverted. The count, the registers and the control word can be rewritten while the timer runs.

Top module: `gp_timer`

## Requirements
- R1: After reset (rst_n low) the count, the captured value, the event flags and the interrupt line are all zero, and pwm_o is 0.
- R2: Control word bit 0 (write address 0) is the run bit. While it is 0, the count holds its value. While it is 1, the count advances on each prescaler tick.
- R3: When control bit 3 is 0 the prescaler is bypassed and the count advances on every clock. When bit 3 is 1, the 4-bit field in bits 7:4 gives n, and the count advances once every 2^n clocks. Any value of n above 8 is treated as 8. Advancing starts from the edge that sets the run bit.
- R4: An advance from the all-ones value with control bit 1 clear makes the count zero and sets event flag bit 0 (overflow) on the same edge.
- R5: With control bit 1 (auto-reload) set, an advance from all-ones loads the value written to address 1 instead of zero.
- R6: With control bit 2 (one-shot) set and bit 1 clear, the overflow clears the run bit, so the count then stays at zero.
- R7: Event flag bit 1 (compare) is set on the edge where an advance makes the count equal to the value written to address 2.
- R8: Control bits 9:8 select the capture edge: 0 none, 1 rising, 2 falling, 3 both. cap_in passes through two synchronizer flops. A selected edge that is set up before clock edge k loads the count into capture_o at edge k+2 and sets event flag bit 2. An edge that is not selected changes neither.
- R9: Event flags are sticky. Writing to address 4 clears each flag whose data bit is 1. Address 5 holds a 3-bit enable mask, and irq_o is high whenever a flag and its enable bit are both set.
- R10: With control bit 10 at 0, the PWM state toggles on each edge that carries an overflow or compare event. With bit 10 at 1, the state is high for exactly the one clock that follows such an edge. pwm_o is this state XORed with control bit 11. Any write to the control word clears the state.
- R11: A write to address 3 sets the count on the next edge, takes priority over counting and restarts the prescaler. With n = 2 the first advance after the write therefore comes 4 clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 reload, 2 compare, 3 count, 4 flag clear, 5 enable) |
| wr_data | input | 32 | Write data |
| cap_in | input | 1 | Asynchronous capture pin |
| count_o | output | 32 | Live counter value |
| capture_o | output | 32 | Last captured value |
| irq_status_o | output | 3 | Sticky flags: bit 0 overflow, bit 1 compare, bit 2 capture |
| pwm_o | output | 1 | Trigger/PWM output |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that wr_en, wr_addr and wr_data are stable around the clock edge. They also assume that a write is a single clean transfer per cycle, so a count write and a tick are never both expected to land on one edge. The stimulus changes every input only at the falling clock edge and issues one write per cycle. cap_in is held for at least three clocks between transitions, so the synchronizer never drops an edge that a check depends on.

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int WIDTH   = 32,
  parameter int PRE_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             cap_in,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] capture_o,
  output logic [2:0]       irq_status_o,
  output logic             pwm_o,
  output logic             irq_o
);
  localparam int CW = 12;
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [CW-1:0]      ctrl_q;
  logic [WIDTH-1:0]   load_q, cmp_q, cnt_q, cap_q, cnt_nxt;
  logic [2:0]         st_q, en_q, sync_q;
  logic [PRE_MAX-1:0] pre_q, pre_lim;
  logic [3:0]         n_eff;
  logic               pwm_q;

  wire run    = ctrl_q[0];
  wire auto_r = ctrl_q[1];
  wire oneshot = ctrl_q[2];
  wire pre_en = ctrl_q[3];
  wire pulse  = ctrl_q[10];

  wire wr_ctrl = wr_en && wr_addr == 3'd0;
  wire wr_load = wr_en && wr_addr == 3'd1;
  wire wr_cmp  = wr_en && wr_addr == 3'd2;
  wire wr_cnt  = wr_en && wr_addr == 3'd3;
  wire wr_st   = wr_en && wr_addr == 3'd4;
  wire wr_ien  = wr_en && wr_addr == 3'd5;

  assign n_eff   = (ctrl_q[7:4] > 4'(PRE_MAX)) ? 4'(PRE_MAX) : ctrl_q[7:4];
  assign pre_lim = ~({PRE_MAX{1'b1}} << n_eff);

  wire tick = run && (!pre_en || pre_q == pre_lim);
  wire adv  = tick && !wr_cnt;
  wire ovf  = adv && cnt_q == CNT_MAX;
  assign cnt_nxt = ovf ? (auto_r ? load_q : '0) : cnt_q + 1'b1;
  wire cmp_ev = adv && cnt_nxt == cmp_q;

  wire rise   = sync_q[1] & ~sync_q[2];
  wire fall   = ~sync_q[1] & sync_q[2];
  wire cap_ev = (ctrl_q[8] & rise) | (ctrl_q[9] & fall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      cnt_q  <= '0;
      cap_q  <= '0;
      st_q   <= '0;
      en_q   <= '0;
      sync_q <= '0;
      pre_q  <= '0;
      pwm_q  <= 1'b0;
    end else begin
      if (wr_ctrl)                         ctrl_q <= wr_data[CW-1:0];
      else if (ovf && oneshot && !auto_r)  ctrl_q[0] <= 1'b0;
      if (wr_load) load_q <= wr_data;
      if (wr_cmp)  cmp_q  <= wr_data;
      if (wr_ien)  en_q   <= wr_data[2:0];

      if (wr_cnt)   cnt_q <= wr_data;
      else if (adv) cnt_q <= cnt_nxt;

      if (wr_cnt || !run || tick) pre_q <= '0;
      else if (pre_en)            pre_q <= pre_q + 1'b1;

      sync_q <= {sync_q[1:0], cap_in};
      if (cap_ev) cap_q <= cnt_q;

      st_q <= (st_q & ~(wr_st ? wr_data[2:0] : 3'b000)) | {cap_ev, cmp_ev, ovf};

      if (wr_ctrl)           pwm_q <= 1'b0;
      else if (pulse)        pwm_q <= ovf | cmp_ev;
      else if (ovf | cmp_ev) pwm_q <= ~pwm_q;
    end
  end

  assign count_o      = cnt_q;
  assign capture_o    = cap_q;
  assign irq_status_o = st_q;
  assign pwm_o        = pwm_q ^ ctrl_q[11];
  assign irq_o        = |(st_q & en_q);

  // R11
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wr_data));
  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q));
  // R3
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_en && pre_q != pre_lim && !wr_cnt) |=> $stable(cnt_q));
  // R4
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_q == CNT_MAX && !auto_r) |=> (cnt_q == '0 && st_q[0]));
  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && oneshot && !auto_r && !wr_ctrl) |=> !ctrl_q[0]);
  // R9
  sticky_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[1] && !(wr_st && wr_data[1])) |=> st_q[1]);
endmodule

// File: tb/gp_timer_tb.sv
module gp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cap_in = 1'b0;
  logic [31:0] count_o, capture_o;
  logic [2:0]  irq_status_o;
  logic        pwm_o, irq_o;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_in(cap_in), .count_o(count_o),
    .capture_o(capture_o), .irq_status_o(irq_status_o),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  // prescaler vectors: enable, n, clocks run, expected count
  localparam int PV [6][4] = '{
    '{0, 5, 20, 20}, '{1, 0, 20, 20}, '{1, 1, 20, 10},
    '{1, 3, 40, 5},  '{1, 8, 512, 2}, '{1, 12, 512, 2}
  };

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 count", count_o, 0);
    chk("R1 capture", capture_o, 0);
    chk("R1 flags", {29'd0, irq_status_o}, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 pwm", {31'd0, pwm_o}, 0);

    wr(3'd2, 32'h100);
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, 0);
      wr(3'd3, 0);
      wr(3'd0, 32'h1 | (PV[i][0] << 3) | (PV[i][1] << 4));
      wait_n(PV[i][2]);
      chk("R3 prescale", count_o, PV[i][3]);
    end

    // R2 stop and start
    wr(3'd0, 0); wr(3'd3, 7);
    wait_n(10);
    chk("R2 hold", count_o, 7);
    wr(3'd0, 1);
    wait_n(3);
    chk("R2 run", count_o, 10);

    // R4 overflow
    wr(3'd0, 0); wr(3'd4, 7); wr(3'd3, 32'hFFFF_FFFE); wr(3'd0, 1);
    wait_n(1);
    chk("R4 before", count_o, 32'hFFFF_FFFF);
    chk("R4 flag clear", {29'd0, irq_status_o} & 1, 0);
    wait_n(1);
    chk("R4 wrap", count_o, 0);
    chk("R4 flag", {29'd0, irq_status_o} & 1, 1);

    // R5 auto-reload
    wr(3'd0, 0); wr(3'd1, 32'h50); wr(3'd3, 32'hFFFF_FFFF); wr(3'd0, 3);
    wait_n(1);
    chk("R5 reload", count_o, 32'h50);
    wait_n(1);
    chk("R5 continue", count_o, 32'h51);

    // R6 one-shot
    wr(3'd0, 0); wr(3'd3, 32'hFFFF_FFFF); wr(3'd0, 5);
    wait_n(1);
    chk("R6 wrap", count_o, 0);
    wait_n(5);
    chk("R6 stopped", count_o, 0);

    // R7 compare
    wr(3'd0, 0); wr(3'd4, 7); wr(3'd2, 32'h10); wr(3'd3, 32'h0C); wr(3'd0, 1);
    wait_n(3);
    chk("R7 no match yet", {29'd0, irq_status_o} & 2, 0);
    wait_n(1);
    chk("R7 match", {29'd0, irq_status_o} & 2, 2);
    wr(3'd0, 0);

    // R9 sticky, write-1-clear, interrupt mask
    chk("R9 masked", {31'd0, irq_o}, 0);
    wr(3'd5, 2);
    chk("R9 irq", {31'd0, irq_o}, 1);
    wr(3'd4, 1);
    chk("R9 sticky", {29'd0, irq_status_o} & 2, 2);
    wr(3'd4, 2);
    chk("R9 cleared", {29'd0, irq_status_o} & 2, 0);
    chk("R9 irq low", {31'd0, irq_o}, 0);

    // R11 count write while running with prescale n=2
    wr(3'd3, 0); wr(3'd0, 32'h29);
    wait_n(7);
    wr(3'd3, 32'h100);
    chk("R11 written", count_o, 32'h100);
    wait_n(3);
    chk("R11 prescale restart", count_o, 32'h100);
    wait_n(1);
    chk("R11 first tick", count_o, 32'h101);

    // R8 capture
    wr(3'd0, 0); wr(3'd3, 32'h1234); wr(3'd0, 32'h100);
    cap_in = 1'b1;
    wait_n(2);
    chk("R8 latency", {29'd0, irq_status_o} & 4, 0);
    wait_n(1);
    chk("R8 rising", capture_o, 32'h1234);
    chk("R8 flag", {29'd0, irq_status_o} & 4, 4);
    wr(3'd3, 32'h2222);
    cap_in = 1'b0;
    wait_n(5);
    chk("R8 fall ignored", capture_o, 32'h1234);
    wr(3'd0, 32'h200);
    cap_in = 1'b1;
    wait_n(5);
    chk("R8 rise ignored", capture_o, 32'h1234);
    cap_in = 1'b0;
    wait_n(3);
    chk("R8 falling", capture_o, 32'h2222);
    wr(3'd0, 32'h300); wr(3'd3, 32'h4444);
    cap_in = 1'b1;
    wait_n(3);
    chk("R8 both", capture_o, 32'h4444);
    wr(3'd0, 0); wr(3'd3, 32'h5555);
    cap_in = 1'b0;
    wait_n(5);
    chk("R8 none", capture_o, 32'h4444);

    // R10 toggle mode
    wr(3'd2, 32'h10); wr(3'd3, 32'h0E); wr(3'd0, 1);
    wait_n(1);
    chk("R10 toggle low", {31'd0, pwm_o}, 0);
    wait_n(1);
    chk("R10 toggle on compare", {31'd0, pwm_o}, 1);
    wr(3'd3, 32'hFFFF_FFFE);
    wait_n(1);
    chk("R10 hold", {31'd0, pwm_o}, 1);
    wait_n(1);
    chk("R10 toggle on overflow", {31'd0, pwm_o}, 0);
    wr(3'd0, 32'h801);
    chk("R10 inverted", {31'd0, pwm_o}, 1);

    // R10 pulse mode
    wr(3'd0, 0); wr(3'd3, 32'h0E); wr(3'd0, 32'h401);
    wait_n(1);
    chk("R10 pulse idle", {31'd0, pwm_o}, 0);
    wait_n(1);
    chk("R10 pulse high", {31'd0, pwm_o}, 1);
    wait_n(1);
    chk("R10 pulse one clock", {31'd0, pwm_o}, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule